// File: doc/BRIEF.md
# External Bus Write Strobe Controller

This block turns one internal write request into a complete write cycle on an asynchronous external bus. It orders the four phases of the cycle: region select and address, the write strobe, data drive, and a release phase. It runs on a clock at twice the peripheral rate. One clock cycle, called a tick here, is therefore half a peripheral period, and every half-period offset the bus needs falls on a clock edge.

The strobe can be stretched in three ways, chosen per request: a programmed waitstate count, the external acknowledge input, or both, with the waitstates running first. Once acknowledge is seen high, the strobe stays low for two more peripheral periods. A per-request hold flag keeps the data driven for one extra peripheral period after the strobe rises. The block decodes six active-low region selects: four memory regions, one I/O region and one boot region.

Top module: `xbw_write_ctrl`

## Requirements
- R1: During and after reset, and whenever busy is low, the write strobe is high, all six selects are high (inactive), data enable is low, and done and busy are low.
- R2: A request accepted while idle selects region index `region_i` (0 to 3 memory, 4 I/O, 5 boot). It drives select bit `sel_n_o[region_i]` low and presents the captured address on `addr_o`. Select and address become valid exactly one tick before the strobe falls, and only one select is ever low.
- R3: Mode 0 (waitstates only): the strobe stays low for 2 + 2·W ticks, where W is `wait_i`, and the acknowledge input has no effect.
- R4: Mode 1 (acknowledge only): W is ignored. The strobe stays low 2 ticks, then acknowledge is sampled on every clock edge. After the first high sample the strobe stays low 4 more ticks, so for acknowledge first seen high in strobe tick T its low time is max(3, T) + 4 ticks.
- R5: Mode 2 (combined): acknowledge is sampled only after the 2 + 2·W waitstate ticks. The strobe low time is max(3 + 2·W, T) + 4 ticks.
- R6: Select and address stay valid one tick after the strobe rises.
- R7: Data enable rises in the same tick as the strobe falls, and `data_o` carries the captured data. Data stays driven 1 tick after the strobe rises, or 3 ticks when `hold_i` was set with the request.
- R8: Busy is high from the tick after acceptance until the final tick. Done pulses high for exactly that final tick, which follows the data release. A request raised while busy is ignored: no second cycle starts, and the captured address does not change.
- R9: Between the strobe rising and the next strobe falling, at least 2 ticks (one peripheral period) pass, even with the request held high continuously.
- R10: Mode 3 behaves exactly like mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the peripheral rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Write request, accepted when idle |
| addr_i | input | 22 | Write address |
| data_i | input | 16 | Write data |
| region_i | input | 3 | Region index (0-3 memory, 4 I/O, 5 boot) |
| wait_i | input | 4 | Waitstate count W, in peripheral periods |
| mode_i | input | 2 | Stretch mode: 0 wait, 1 ack, 2 and 3 combined |
| hold_i | input | 1 | Extend data hold by one peripheral period |
| ack_i | input | 1 | External acknowledge, high lets the cycle finish |
| sel_n_o | output | 6 | Active-low region selects |
| wr_n_o | output | 1 | Active-low write strobe |
| addr_o | output | 22 | Address bus |
| data_o | output | 16 | Data bus value |
| data_oe_o | output | 1 | Data bus output enable |
| done_o | output | 1 | One-tick completion pulse |
| busy_o | output | 1 | Cycle in progress |

## Verification
The bench targets these corner cases:
- Acknowledge already high when waiting begins. A design that skips the tail would end the strobe 4 ticks early.
- Acknowledge rising several ticks after the waitstates expire. Sampling it during waitstates in combined mode shortens the strobe.
- The largest waitstate count, which would expose a counter that is too narrow.
- The hold flag. A design that also stretched the select would show a longer select window.
- A request raised in the middle of a cycle. A design that accepts it would restart the cycle or overwrite the address.
- The request held high across two cycles. A design without a recovery phase would shrink the strobe-high gap below one peripheral period.

// File: rtl/xbw_pkg.sv
package xbw_pkg;

   typedef enum logic [2:0] {
      XS_IDLE    = 3'd0,
      XS_SETUP   = 3'd1,
      XS_STROBE  = 3'd2,
      XS_ACKWAIT = 3'd3,
      XS_TAIL    = 3'd4,
      XS_HOLD    = 3'd5,
      XS_RECOVER = 3'd6
   } xbw_state_e;

   typedef enum logic [1:0] {
      XM_WAIT  = 2'd0,
      XM_ACK   = 2'd1,
      XM_BOTH  = 2'd2,
      XM_BOTH2 = 2'd3
   } xbw_mode_e;

   // ticks of strobe after acknowledge is seen high (two peripheral periods)
   localparam int unsigned XBW_TAIL_TICKS = 4;
   // extra data-hold ticks when hold is requested (one peripheral period)
   localparam int unsigned XBW_HOLD_XTRA  = 2;

endpackage

// File: rtl/xbw_capture.sv
module xbw_capture
   import xbw_pkg::*;
#(
   parameter int unsigned ADDR_W   = 22,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned REGION_W = 3,
   parameter int unsigned WAIT_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   data_i,
   input  logic [REGION_W-1:0] region_i,
   input  logic [WAIT_W-1:0]   wait_i,
   input  xbw_mode_e           mode_i,
   input  logic                hold_i,
   output logic [ADDR_W-1:0]   addr_q,
   output logic [DATA_W-1:0]   data_q,
   output logic [REGION_W-1:0] region_q,
   output logic [WAIT_W-1:0]   wait_q,
   output xbw_mode_e           mode_q,
   output logic                hold_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         data_q   <= '0;
         region_q <= '0;
         wait_q   <= '0;
         mode_q   <= XM_WAIT;
         hold_q   <= 1'b0;
      end else if (take_i) begin
         addr_q   <= addr_i;
         data_q   <= data_i;
         region_q <= region_i;
         wait_q   <= wait_i;
         mode_q   <= mode_i;
         hold_q   <= hold_i;
      end
   end

endmodule

// File: rtl/xbw_seq.sv
module xbw_seq
   import xbw_pkg::*;
#(
   parameter int unsigned WAIT_W     = 4,
   parameter int unsigned CNT_W      = WAIT_W + 2,
   parameter int unsigned TAIL_TICKS = XBW_TAIL_TICKS,
   parameter int unsigned HOLD_XTRA  = XBW_HOLD_XTRA,
   parameter int unsigned ACK_SYNC   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  xbw_mode_e         mode_i,
   input  logic [WAIT_W-1:0] wait_i,
   input  logic              hold_i,
   input  logic              ack_i,
   output logic              take_o,
   output xbw_state_e        state_o,
   output logic              hold_lead_o
);

   localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_TICKS - 1);
   localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_XTRA);

   xbw_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] strobe_last;
   logic [CNT_W-1:0] hold_last;
   logic             ack_s;

   // acknowledge path: direct sampling or a synchronizer chain
   generate
      if (ACK_SYNC == 0) begin : g_ack_direct
         assign ack_s = ack_i;
      end else begin : g_ack_sync
         logic [ACK_SYNC-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[ACK_SYNC-2:0], ack_i};
         end
         assign ack_s = chain[ACK_SYNC-1];
      end
   endgenerate

   // base strobe length minus one: acknowledge-only ignores waitstates
   always_comb begin
      if (mode_i == XM_ACK) strobe_last = CNT_W'(1);
      else                  strobe_last = CNT_W'({wait_i, 1'b0}) + CNT_W'(1);
      hold_last = hold_i ? HOLD_LAST : '0;
   end

   assign take_o      = req_i && (state == XS_IDLE);
   assign state_o     = state;
   assign hold_lead_o = (state == XS_HOLD) && (cnt == hold_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= XS_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            XS_IDLE: begin
               if (req_i) state <= XS_SETUP;
            end
            XS_SETUP: begin
               state <= XS_STROBE;
               cnt   <= strobe_last;
            end
            XS_STROBE: begin
               if (cnt != '0) begin
                  cnt <= cnt - CNT_W'(1);
               end else if (mode_i == XM_WAIT) begin
                  state <= XS_HOLD;
                  cnt   <= hold_last;
               end else begin
                  state <= XS_ACKWAIT;
               end
            end
            XS_ACKWAIT: begin
               if (ack_s) begin
                  state <= XS_TAIL;
                  cnt   <= TAIL_LAST;
               end
            end
            XS_TAIL: begin
               if (cnt != '0) begin
                  cnt <= cnt - CNT_W'(1);
               end else begin
                  state <= XS_HOLD;
                  cnt   <= hold_last;
               end
            end
            XS_HOLD: begin
               if (cnt != '0) cnt <= cnt - CNT_W'(1);
               else           state <= XS_RECOVER;
            end
            XS_RECOVER: begin
               state <= XS_IDLE;
            end
            default: begin
               state <= XS_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/xbw_drive.sv
module xbw_drive
   import xbw_pkg::*;
#(
   parameter int unsigned ADDR_W   = 22,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned N_SEL    = 6,
   parameter int unsigned REGION_W = 3
) (
   input  xbw_state_e          state_i,
   input  logic                hold_lead_i,
   input  logic [REGION_W-1:0] region_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   data_i,
   output logic [N_SEL-1:0]    sel_n_o,
   output logic                wr_n_o,
   output logic [ADDR_W-1:0]   addr_o,
   output logic [DATA_W-1:0]   data_o,
   output logic                data_oe_o,
   output logic                done_o,
   output logic                busy_o
);

   logic sel_on;
   logic strobe_on;

   always_comb begin
      strobe_on = state_i inside {XS_STROBE, XS_ACKWAIT, XS_TAIL};
      sel_on    = strobe_on || (state_i == XS_SETUP) || hold_lead_i;
      data_oe_o = strobe_on || (state_i == XS_HOLD);
      wr_n_o    = !strobe_on;
      done_o    = (state_i == XS_RECOVER);
      busy_o    = (state_i != XS_IDLE);
      addr_o    = addr_i;
      data_o    = data_oe_o ? data_i : '0;
   end

   generate
      for (genvar gi = 0; gi < N_SEL; gi++) begin : g_sel
         assign sel_n_o[gi] = !(sel_on && (region_i == REGION_W'(gi)));
      end
   endgenerate

endmodule

// File: rtl/xbw_write_ctrl.sv
module xbw_write_ctrl
   import xbw_pkg::*;
#(
   parameter int unsigned ADDR_W   = 22,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned N_SEL    = 6,
   parameter int unsigned WAIT_W   = 4,
   parameter int unsigned ACK_SYNC = 0,
   localparam int unsigned REGION_W = (N_SEL > 1) ? $clog2(N_SEL) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   data_i,
   input  logic [REGION_W-1:0] region_i,
   input  logic [WAIT_W-1:0]   wait_i,
   input  logic [1:0]          mode_i,
   input  logic                hold_i,
   input  logic                ack_i,
   output logic [N_SEL-1:0]    sel_n_o,
   output logic                wr_n_o,
   output logic [ADDR_W-1:0]   addr_o,
   output logic [DATA_W-1:0]   data_o,
   output logic                data_oe_o,
   output logic                done_o,
   output logic                busy_o
);

   localparam int unsigned CNT_W = WAIT_W + 2;

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
         $error("xbw_write_ctrl: bus widths must be positive");
      end
      if (N_SEL < 1) begin : g_bad_sel
         $error("xbw_write_ctrl: at least one region select is needed");
      end
      if (WAIT_W < 1) begin : g_bad_wait
         $error("xbw_write_ctrl: wait count needs at least one bit");
      end
      if (XBW_TAIL_TICKS > (1 << CNT_W) || XBW_HOLD_XTRA >= (1 << CNT_W)) begin : g_bad_cnt
         $error("xbw_write_ctrl: tick counter too narrow");
      end
      if (ACK_SYNC == 1) begin : g_bad_sync
         $error("xbw_write_ctrl: acknowledge synchronizer needs 0 or at least 2 stages");
      end
   endgenerate

   xbw_state_e          state;
   logic                take;
   logic                hold_lead;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   data_q;
   logic [REGION_W-1:0] region_q;
   logic [WAIT_W-1:0]   wait_q;
   xbw_mode_e           mode_q;
   logic                hold_q;

   xbw_capture #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REGION_W (REGION_W),
      .WAIT_W   (WAIT_W)
   ) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_i   (take),
      .addr_i   (addr_i),
      .data_i   (data_i),
      .region_i (region_i),
      .wait_i   (wait_i),
      .mode_i   (xbw_mode_e'(mode_i)),
      .hold_i   (hold_i),
      .addr_q   (addr_q),
      .data_q   (data_q),
      .region_q (region_q),
      .wait_q   (wait_q),
      .mode_q   (mode_q),
      .hold_q   (hold_q)
   );

   xbw_seq #(
      .WAIT_W     (WAIT_W),
      .CNT_W      (CNT_W),
      .TAIL_TICKS (XBW_TAIL_TICKS),
      .HOLD_XTRA  (XBW_HOLD_XTRA),
      .ACK_SYNC   (ACK_SYNC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req_i),
      .mode_i      (mode_q),
      .wait_i      (wait_q),
      .hold_i      (hold_q),
      .ack_i       (ack_i),
      .take_o      (take),
      .state_o     (state),
      .hold_lead_o (hold_lead)
   );

   xbw_drive #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .N_SEL    (N_SEL),
      .REGION_W (REGION_W)
   ) u_drive (
      .state_i     (state),
      .hold_lead_i (hold_lead),
      .region_i    (region_q),
      .addr_i      (addr_q),
      .data_i      (data_q),
      .sel_n_o     (sel_n_o),
      .wr_n_o      (wr_n_o),
      .addr_o      (addr_o),
      .data_o      (data_o),
      .data_oe_o   (data_oe_o),
      .done_o      (done_o),
      .busy_o      (busy_o)
   );

endmodule

// File: rtl/xbw_write_chk.sv
module xbw_write_chk #(
   parameter int unsigned N_SEL = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SEL-1:0] sel_n,
   input logic             wr_n,
   input logic             data_oe,
   input logic             done,
   input logic             busy
);

   AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (wr_n && !data_oe && !done && (sel_n == '1))); // R1

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~sel_n) <= 1); // R2

   AST_SEL_LEADS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_n) |-> ($past(sel_n) != '1) && $past(busy)); // R2

   AST_SEL_TRAILS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> (sel_n != '1)); // R6

   AST_DATA_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> data_oe); // R7

   AST_DATA_PAST_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> data_oe); // R7

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_STROBE_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |=> wr_n); // R9

endmodule

bind xbw_write_ctrl xbw_write_chk #(.N_SEL(N_SEL)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel_n   (sel_n_o),
   .wr_n    (wr_n_o),
   .data_oe (data_oe_o),
   .done    (done_o),
   .busy    (busy_o)
);

// File: tb/sim_xbw_write_ctrl.sv
`timescale 1ns/1ps
module sim_xbw_write_ctrl;

   typedef struct packed {
      logic [1:0]  md;
      logic [3:0]  w;
      logic [2:0]  rg;
      logic        hd;
      logic [7:0]  t;
      logic [21:0] a;
      logic [15:0] d;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 4'd0,  3'd0, 1'b0, 8'd0,  22'h000001, 16'hA5A5},
      '{2'd0, 4'd3,  3'd2, 1'b1, 8'd0,  22'h2AAAAA, 16'h1234},
      '{2'd1, 4'd5,  3'd1, 1'b0, 8'd0,  22'h155555, 16'hFFFF},
      '{2'd1, 4'd0,  3'd3, 1'b0, 8'd9,  22'h3FFFFF, 16'h0001},
      '{2'd2, 4'd2,  3'd4, 1'b1, 8'd0,  22'h000400, 16'h8000},
      '{2'd2, 4'd1,  3'd5, 1'b0, 8'd12, 22'h123456, 16'h5A5A},
      '{2'd3, 4'd2,  3'd0, 1'b0, 8'd10, 22'h0F0F0F, 16'hC3C3},
      '{2'd0, 4'd15, 3'd1, 1'b1, 8'd0,  22'h200000, 16'h7E7E}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [21:0] addr_i = '0;
   logic [15:0] data_i = '0;
   logic [2:0]  region_i = '0;
   logic [3:0]  wait_i = '0;
   logic [1:0]  mode_i = '0;
   logic        hold_i = 1'b0;
   logic        ack_i = 1'b0;
   logic [5:0]  sel_n_o;
   logic        wr_n_o;
   logic [21:0] addr_o;
   logic [15:0] data_o;
   logic        data_oe_o;
   logic        done_o;
   logic        busy_o;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   xbw_write_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i), .data_i(data_i),
      .region_i(region_i), .wait_i(wait_i), .mode_i(mode_i), .hold_i(hold_i),
      .ack_i(ack_i), .sel_n_o(sel_n_o), .wr_n_o(wr_n_o), .addr_o(addr_o),
      .data_o(data_o), .data_oe_o(data_oe_o), .done_o(done_o), .busy_o(busy_o)
   );

   task automatic chk(input string rq, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
      end
   endtask

   function automatic int exp_strobe(input vec_t v);
      int b;
      b = 2 + ((v.md == 2'd1) ? 0 : 2 * int'(v.w));
      if (v.md == 2'd0) return b;
      return (((b + 1) > int'(v.t)) ? (b + 1) : int'(v.t)) + 4;
   endfunction

   task automatic run_cycle(input vec_t v, input int intr);
      int first_sel = -1, last_sel = -1, first_wr = -1, last_wr = -1;
      int first_oe = -1, last_oe = -1;
      int wcnt = 0, noe = 0, nbusy = 0, ndone = 0, bad_sel = 0, bad_addr = 0, bad_data = 0;
      int s, h, late_busy;
      string tg;
      s  = exp_strobe(v);
      h  = v.hd ? 3 : 1;
      tg = (v.md == 2'd0) ? "R3" : (v.md == 2'd1) ? "R4" : (v.md == 2'd2) ? "R5" : "R10";
      @(negedge clk);
      mode_i = v.md; wait_i = v.w; region_i = v.rg; hold_i = v.hd;
      addr_i = v.a; data_i = v.d;
      ack_i = (v.t == 8'd0) && (v.md != 2'd0);
      req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      for (int t = 1; t <= 400; t++) begin
         if (sel_n_o != 6'h3F) begin
            if (first_sel < 0) first_sel = t;
            last_sel = t;
            if (sel_n_o != ~(6'b1 << v.rg)) bad_sel++;
            if (addr_o != v.a) bad_addr++;
         end
         if (!wr_n_o) begin
            wcnt++;
            if (first_wr < 0) first_wr = t;
            last_wr = t;
            if (wcnt == int'(v.t)) ack_i = 1'b1;
         end
         if (data_oe_o) begin
            noe++;
            if (first_oe < 0) first_oe = t;
            last_oe = t;
            if (data_o != v.d) bad_data++;
         end
         if (busy_o) nbusy++;
         if (done_o) ndone++;
         if (t == intr) begin
            req_i = 1'b1; addr_i = ~v.a; data_i = ~v.d;
         end else if (t == intr + 1) begin
            req_i = 1'b0;
         end
         if (!busy_o) break;
         @(negedge clk);
      end
      ack_i = 1'b0;
      chk(tg, "strobe low ticks", wcnt, s);
      chk("R2", "select lead ticks", first_wr - first_sel, 1);
      chk("R2", "wrong select bit", bad_sel, 0);
      chk("R2", "address mismatch while selected", bad_addr, 0);
      chk("R6", "select trail ticks", last_sel - last_wr, 1);
      chk("R7", "data enable start vs strobe", first_oe - first_wr, 0);
      chk("R7", "data enable ticks", noe, s + h);
      chk("R7", "data trail ticks", last_oe - last_wr, h);
      chk("R7", "data mismatch while driven", bad_data, 0);
      chk("R8", "busy ticks", nbusy, s + h + 2);
      chk("R8", "done pulses", ndone, 1);
      if (intr > 0) begin
         late_busy = 0;
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (busy_o) late_busy++;
         end
         chk("R8", "busy after ignored request", late_busy, 0);
         chk("R8", "address kept after ignored request", int'(addr_o == v.a), 1);
      end
   endtask

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog: run did not finish, got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      vec_t dv;
      int phase, gap, lastw;
      // reset state, R1
      @(negedge clk);
      chk("R1", "strobe in reset", int'(wr_n_o), 1);
      chk("R1", "selects in reset", int'(sel_n_o), 63);
      chk("R1", "data enable in reset", int'(data_oe_o), 0);
      chk("R1", "busy/done in reset", int'({busy_o, done_o}), 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "strobe after reset", int'(wr_n_o), 1);
      chk("R1", "busy after reset", int'(busy_o), 0);

      // vector table
      for (int i = 0; i < NV; i++) run_cycle(VECS[i], 0);

      // R8: request during a busy cycle is ignored
      dv = '{2'd0, 4'd4, 3'd2, 1'b0, 8'd0, 22'h0ABCDE, 16'h4242};
      run_cycle(dv, 4);

      // R3: acknowledge held low has no effect in waitstate mode (vector 0 ran with ack low)
      // R9: request held high across two cycles
      @(negedge clk);
      mode_i = 2'd0; wait_i = 4'd0; region_i = 3'd0; hold_i = 1'b0;
      addr_i = 22'h00AA55; data_i = 16'h0F0F; req_i = 1'b1;
      phase = 0; gap = 0; lastw = 1;
      for (int t = 0; t < 60 && phase < 3; t++) begin
         @(negedge clk);
         if (phase == 0 && !wr_n_o) phase = 1;
         else if (phase == 1 && wr_n_o) begin phase = 2; gap = 1; end
         else if (phase == 2) begin
            if (wr_n_o) gap++;
            else phase = 3;
         end
         lastw = int'(wr_n_o);
      end
      req_i = 1'b0;
      tests++;
      if (phase != 3 || gap < 2) begin
         fails++;
         $display("FAIL R9 strobe high gap: got %0d expected at least 2 (phase %0d, last %0d)", gap, phase, lastw);
      end
      for (int t = 0; t < 80 && busy_o; t++) @(negedge clk);
      repeat (2) @(negedge clk);
      chk("R1", "idle strobe after back-to-back", int'(wr_n_o), 1);
      chk("R1", "idle selects after back-to-back", int'(sel_n_o), 63);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule